// File: doc/BRIEF.md
# Programmable Pulse-to-Ready Delay Timer

This block enforces a minimum wait after a single-cycle trigger pulse, the kind of spacing a memory controller needs between two commands. When the trigger is seen, the block captures a delay value N and counts down. After N clock cycles it raises a level-style ready output, which then stays high. Alongside that level it raises a one-cycle ready pulse in the first cycle that ready is high. A delay of zero bypasses the counter: ready and the pulse go high combinationally in the trigger cycle itself.

The delay comes from one of two sources, chosen by a parameter. It can be a runtime input that is sampled only in the trigger cycle, or a constant fixed at elaboration. A new trigger always restarts the wait. This holds whether a count is still running or ready is already high. All pins are plain control and status signals: there is no data stream and no back-pressure.

Top module: `pulse_delay_timer`

## Requirements
- R1: After synchronous reset, and until the first trigger, `ready_o` and `ready_pulse_o` are both 0.
- R2: With a captured delay N in 1..7, `ready_o` first reads 1 in the cycle exactly N cycles after the cycle in which `trig_i` was 1. So N=1 gives the next cycle and N=4 gives the fourth cycle after.
- R3: With a captured delay of 0, `ready_o` and `ready_pulse_o` are both 1 in the same cycle as `trig_i`, through a combinational path. `ready_o` then stays 1 in the following cycles.
- R4: Once `ready_o` is 1, it stays 1 in every later cycle until another trigger arrives.
- R5: `ready_pulse_o` is 1 for exactly one cycle per trigger. That cycle is the first one after the trigger in which `ready_o` is 1; in every other cycle the pulse is 0.
- R6: In runtime mode (`USE_RUNTIME`=1) the delay is the 3-bit unsigned value on `delay_i` (0..7) in the trigger cycle. Changes to `delay_i` in any other cycle do not alter a running count.
- R7: A trigger during a count, or after ready has risen, restarts the wait with the new delay. For a new delay N>0, `ready_o` reads 0 from the cycle after the trigger until the new count expires.
- R8: In fixed mode (`USE_RUNTIME`=0) the delay is always `FIXED_DLY`, and `delay_i` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | One-cycle trigger that starts or restarts the wait |
| delay_i | input | DLY_W (3) | Runtime delay, sampled in the trigger cycle (runtime mode only) |
| ready_o | output | 1 | High once the wait has elapsed; sticky until the next trigger |
| ready_pulse_o | output | 1 | High in the first cycle of ready after each trigger |

## Verification
Two cases are hard to reach from the ports. The first is a trigger that lands on the same cycle in which a previous wait expires or has just produced its pulse. The second is a delay input that changes while a count is running. The bench reaches both with directed sequences. It retriggers every delay value 0..7 at fixed offsets from the previous trigger, including back-to-back triggers in adjacent cycles. It also walks `delay_i` through other values on every non-trigger cycle of a long count. A cycle-level reference model, driven only by the trigger history and the delays captured at triggers, predicts both outputs in every cycle. It does this for a runtime instance and for a fixed-delay instance at the same time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int TMR_DLY_W_DEF = 3;

  // Phase of the countdown engine
  typedef enum logic [1:0] {
    TM_IDLE    = 2'd0,
    TM_RUN     = 2'd1,
    TM_EXPIRED = 2'd2
  } tmr_phase_e;

endpackage

// File: rtl/tmr_delay_src.sv
module tmr_delay_src #(
  parameter int DLY_W       = 3,
  parameter bit USE_RUNTIME = 1'b1,
  parameter int FIXED_DLY   = 4
) (
  input  logic [DLY_W-1:0] dly_i,
  output logic [DLY_W-1:0] dly_o
);

  generate
    if (USE_RUNTIME) begin : g_runtime
      assign dly_o = dly_i;
    end else begin : g_fixed
      logic unused_dly;
      assign unused_dly = ^dly_i;
      assign dly_o      = DLY_W'(FIXED_DLY);
    end
  endgenerate

endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DLY_W-1:0] val_i,
  output logic             done_o,
  output tmr_phase_e       phase_o
);

  localparam logic [DLY_W-1:0] ONE  = DLY_W'(1);
  localparam logic [DLY_W-1:0] ZERO = '0;

  logic [DLY_W-1:0] cnt_q;
  tmr_phase_e       phase_q;

  // Expiry of a running count (a load always takes precedence)
  assign done_o  = !load_i && (phase_q == TM_RUN) && (cnt_q == ONE);
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ZERO;
      phase_q <= TM_IDLE;
    end else if (load_i) begin
      if (val_i > ONE) begin
        cnt_q   <= val_i - ONE;
        phase_q <= TM_RUN;
      end else begin
        cnt_q   <= ZERO;
        phase_q <= TM_EXPIRED;
      end
    end else if (phase_q == TM_RUN) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) begin
        phase_q <= TM_EXPIRED;
      end
    end
  end

  // R6
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == TM_RUN && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));

  // R2
  run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == TM_RUN) |-> (cnt_q != ZERO));

endmodule

// File: rtl/tmr_flag_stage.sv
module tmr_flag_stage (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic zero_i,
  input  logic one_i,
  input  logic done_i,
  output logic ready_o,
  output logic pulse_o
);

  logic ready_q;
  logic pulse_q;
  logic armed_q;
  logic bypass;

  // Zero-delay trigger reaches the outputs in the same cycle
  assign bypass  = load_i && zero_i;
  assign ready_o = ready_q || bypass;
  assign pulse_o = pulse_q || bypass;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      pulse_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (load_i) begin
        armed_q <= 1'b1;
        ready_q <= zero_i || one_i;
        pulse_q <= one_i;
      end else if (done_i) begin
        ready_q <= 1'b1;
        pulse_q <= 1'b1;
      end else begin
        pulse_q <= 1'b0;
      end
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !load_i) |-> (!ready_o && !pulse_o));

  // R3
  zero_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && zero_i) |-> (ready_o && pulse_o));

  // R4
  sticky_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !load_i) |=> ready_q);

  // R5
  pulse_in_ready_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> ready_o);

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && !load_i) |=> !pulse_q);

  // R2
  expire_sets_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (ready_q && pulse_q));

endmodule

// File: rtl/pulse_delay_timer.sv
module pulse_delay_timer
  import tmr_pkg::*;
#(
  parameter int DLY_W       = TMR_DLY_W_DEF,
  parameter bit USE_RUNTIME = 1'b1,
  parameter int FIXED_DLY   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             ready_o,
  output logic             ready_pulse_o
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] dly_sel;
  logic             cnt_done;
  tmr_phase_e       phase;
  logic             dly_zero;
  logic             dly_one;

  assign dly_zero = (dly_sel == '0);
  assign dly_one  = (dly_sel == ONE);

  tmr_delay_src #(
    .DLY_W      (DLY_W),
    .USE_RUNTIME(USE_RUNTIME),
    .FIXED_DLY  (FIXED_DLY)
  ) u_src (
    .dly_i(delay_i),
    .dly_o(dly_sel)
  );

  tmr_countdown #(
    .DLY_W(DLY_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (trig_i),
    .val_i  (dly_sel),
    .done_o (cnt_done),
    .phase_o(phase)
  );

  tmr_flag_stage u_flag (
    .clk    (clk),
    .rst    (rst),
    .load_i (trig_i),
    .zero_i (dly_zero),
    .one_i  (dly_one),
    .done_i (cnt_done),
    .ready_o(ready_o),
    .pulse_o(ready_pulse_o)
  );

  // R7
  retrig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_i && dly_sel > ONE) |=> (phase == TM_RUN));

  // R7
  running_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == TM_RUN && !trig_i) |-> !ready_o);

endmodule

// File: tb/pulse_delay_timer_tb_top.sv
module pulse_delay_timer_tb_top;

  localparam int FIX = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0;
  logic [2:0] dly = 3'd0;
  logic       rdy_r, pls_r, rdy_f, pls_f;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state: runtime instance (r) and fixed instance (f)
  logic m_st_r, m_pl_r, m_st_f, m_pl_f;
  int   m_left_r, m_left_f;

  always #10 clk = ~clk;

  pulse_delay_timer #(.DLY_W(3), .USE_RUNTIME(1'b1), .FIXED_DLY(4)) dut_i (
    .clk(clk), .rst(rst), .trig_i(trig), .delay_i(dly),
    .ready_o(rdy_r), .ready_pulse_o(pls_r)
  );

  pulse_delay_timer #(.DLY_W(3), .USE_RUNTIME(1'b0), .FIXED_DLY(FIX)) dut_fix_i (
    .clk(clk), .rst(rst), .trig_i(trig), .delay_i(dly),
    .ready_o(rdy_f), .ready_pulse_o(pls_f)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st_r = 0; m_pl_r = 0; m_left_r = 0;
    m_st_f = 0; m_pl_f = 0; m_left_f = 0;
  endtask

  // advance one model at the clock edge
  task automatic model_edge(input logic t, input int d, inout logic st, inout logic pl, inout int left);
    if (t) begin
      if (d == 0)      begin st = 1; pl = 0; left = 0; end
      else if (d == 1) begin st = 1; pl = 1; left = 0; end
      else             begin st = 0; pl = 0; left = d - 1; end
    end else if (left > 0) begin
      left--;
      if (left == 0) begin st = 1; pl = 1; end
      else pl = 0;
    end else begin
      pl = 0;
    end
  endtask

  // one cycle: drive at negedge, sample before the next posedge
  task automatic step(input logic t, input logic [2:0] d, input string tag);
    logic er, ep;
    @(negedge clk);
    trig = t; dly = d;
    #5;
    er = m_st_r || (t && d == 0);
    ep = m_pl_r || (t && d == 0);
    check(tag, "ready(rt)", rdy_r, er);
    check(tag, "pulse(rt)", pls_r, ep);
    check("R8", "ready(fix)", rdy_f, m_st_f);
    check("R8", "pulse(fix)", pls_f, m_pl_f);
    model_edge(t, int'(d), m_st_r, m_pl_r, m_left_r);
    model_edge(t, FIX, m_st_f, m_pl_f, m_left_f);
  endtask

  task automatic t_reset();
    rst = 1'b1; trig = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: idle with various delays, no trigger
    for (int i = 0; i < 4; i++) step(1'b0, 3'(i), "R1");
  endtask

  // R2 / R3: single trigger for each delay, then idle, showing stickiness (R4)
  task automatic t_each_delay();
    for (int d = 0; d < 8; d++) begin
      step(1'b1, 3'(d), d == 0 ? "R3" : "R2");
      for (int c = 0; c < d + 3; c++) step(1'b0, 3'(d), "R4");
    end
  endtask

  // R7: retrigger at every offset during/after a count, every delay
  task automatic t_retrigger();
    for (int d = 0; d < 8; d++) begin
      for (int off = 1; off < 4; off++) begin
        step(1'b1, 3'd3, "R7");
        for (int c = 1; c < off; c++) step(1'b0, 3'd0, "R7");
        step(1'b1, 3'(d), "R7");
        for (int c = 0; c < d + 2; c++) step(1'b0, 3'(d), "R5");
      end
    end
  endtask

  // R7 / R5: back-to-back triggers in adjacent cycles
  task automatic t_back_to_back();
    for (int d = 0; d < 8; d++) begin
      step(1'b1, 3'(d), "R7");
      step(1'b1, 3'((d + 3) % 8), "R7");
      step(1'b1, 3'(7 - d), "R5");
      for (int c = 0; c < 9; c++) step(1'b0, 3'd0, "R5");
    end
  endtask

  // R6: delay input wanders during a running count
  task automatic t_delay_change();
    step(1'b1, 3'd7, "R6");
    for (int c = 0; c < 9; c++) step(1'b0, 3'(c), "R6");
    step(1'b1, 3'd4, "R6");
    for (int c = 0; c < 6; c++) step(1'b0, 3'd0, "R6");
  endtask

  // R8: fixed instance follows FIX whatever delay_i carries
  task automatic t_fixed();
    step(1'b1, 3'd0, "R8");
    for (int c = 0; c < 7; c++) step(1'b0, 3'd1, "R8");
    step(1'b1, 3'd7, "R8");
    for (int c = 0; c < 7; c++) step(1'b0, 3'd2, "R8");
  endtask

  initial begin
    model_reset();
    t_reset();
    t_each_delay();
    t_retrigger();
    t_back_to_back();
    t_delay_change();
    t_fixed();
    // reset again mid-state: outputs return low (R1)
    step(1'b1, 3'd2, "R1");
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule